// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides whether an incoming frame should be kept. It reads the first six bytes of the frame (the destination address) from a byte stream and tests them against four sources of acceptance. Two are programmable station addresses, each with its own enable. One is the all-ones broadcast address. The last is a 64-entry group table indexed by a 6-bit fold of the address. Frames that are too short are dropped whatever their address.

The configuration (both station addresses, the group table, the control bits) and the frame length are sampled when a frame starts. A write to them during a frame therefore affects only later frames. The decision is registered. It appears one clock after the clock edge that captured the sixth address byte and stays on the outputs until the next frame starts. Payload bytes after the address pass by unused.

Top module: `rx_addr_filter`

## Requirements
- R1: A station address is written as a 32-bit low word holding address bytes 0..3 (byte 0 in bits 7:0, byte 3 in bits 31:24) and a 16-bit high word holding byte 4 in bits 7:0 and byte 5 in bits 15:8. Byte 0 is the first byte on the wire. Entry 0 is enabled by control bit 0 and entry 1 by control bit 1. A frame whose six address bytes equal an enabled entry is accepted.
- R2: A station entry whose enable bit is clear never causes acceptance, even when the address equals it exactly.
- R3: With control bit 3 set, the address FF:FF:FF:FF:FF:FF is accepted. With it clear, broadcast gives no acceptance of its own.
- R4: The group index is formed by placing byte k of the address at bits 8k+7..8k of a 48-bit word (bit 0 is the LSB of byte 0) and XOR-ing the eight 6-bit slices of that word. Group word bit i (i = 0..31, low word) or bit i-32 (i = 32..63, high word) being set gives a group match.
- R5: The group lookup is applied only when bit 0 of address byte 0 is 1. Control bit 2 extends it to every address.
- R6: The frame is accepted when at least one of the enabled station matches, the enabled broadcast match or the group match holds, and is dropped otherwise.
- R7: A frame whose length, sampled at start, is below 12 bytes is dropped. A length of 12 is allowed.
- R8: A frame starts on a cycle with both the start strobe and the byte-valid strobe high, and that byte is address byte 0. The decision-valid output rises one clock after the edge that takes address byte 5. It then holds, with a stable accept value, until the edge of the next start, which clears both outputs.
- R9: Configuration and length are sampled at the start edge. Changes applied later in the frame do not alter that frame's decision, and they do apply to the next frame.
- R10: Bytes that follow address byte 5 do not alter the decision. A new start before six address bytes have arrived abandons the partial address and collects from the new byte 0.
- R11: After reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by rx_vld) |
| rx_vld | input | 1 | Byte on rx_byte is valid this cycle |
| rx_byte | input | 8 | Received byte |
| rx_len | input | LEN_W | Frame length in bytes, sampled at start |
| uc0_lo | input | 32 | Station entry 0, bytes 0..3 |
| uc0_hi | input | 16 | Station entry 0, bytes 4..5 |
| uc1_lo | input | 32 | Station entry 1, bytes 0..3 |
| uc1_hi | input | 16 | Station entry 1, bytes 4..5 |
| grp_lo | input | 32 | Group table bits 0..31 |
| grp_hi | input | 32 | Group table bits 32..63 |
| rx_ctrl | input | 4 | bit0 entry 0 enable, bit1 entry 1 enable, bit2 group lookup for all addresses, bit3 broadcast enable |
| dec_valid | output | 1 | Decision is available |
| dec_accept | output | 1 | Frame accepted (meaningful while dec_valid is high) |

## Verification
The bench builds the block with its default parameters (16-bit length, minimum of 12 bytes). At that size every one of the 64 group indices can be reached twice, once with only that table bit set and once with every bit but that one. All sixteen control-bit combinations can also be run against station, broadcast and arbitrary addresses, with fresh tables drawn for each combination. The expected outcome comes from a bit-serial model of the index and a byte-wise station compare in the bench. The length boundary at 11 and 12 bytes, mid-frame configuration writes, trailing payload bytes and an aborted address are all driven explicitly.

// File: rtl/afl_pkg.sv
package afl_pkg;

    // Address geometry
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_BITS  = ADDR_BYTES * 8;
    localparam int REG_W      = 32;
    localparam int HI_W       = ADDR_BITS - REG_W;

    // Group table geometry
    localparam int HASH_W     = 6;
    localparam int GRP_BITS   = 1 << HASH_W;
    localparam int CHUNKS     = ADDR_BITS / HASH_W;

    // Station entries
    localparam int NUM_UC     = 2;

    typedef logic [ADDR_BITS-1:0] mac_t;
    typedef logic [HASH_W-1:0]    hidx_t;

    // Control word; packed so that uc_en sits at bits 1:0, hash_all at 2, bcast_en at 3
    typedef struct packed {
        logic              bcast_en;
        logic              hash_all;
        logic [NUM_UC-1:0] uc_en;
    } rxctl_t;

    // Per-frame configuration image captured at start
    typedef struct packed {
        mac_t [NUM_UC-1:0]   uc;
        logic [GRP_BITS-1:0] grp;
        rxctl_t              ctl;
        logic                len_ok;
    } snap_t;

    // Individual acceptance sources
    typedef struct packed {
        logic [NUM_UC-1:0] uc;
        logic              bcast;
        logic              grp;
    } hits_t;

    function automatic mac_t mac_from_regs(input logic [REG_W-1:0] lo,
                                           input logic [HI_W-1:0]  hi);
        return {hi, lo};
    endfunction

    function automatic hidx_t fold_hash(input mac_t a);
        hidx_t h;
        h = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            h ^= a[c*HASH_W +: HASH_W];
        end
        return h;
    endfunction

endpackage

// File: rtl/afl_byte_collect.sv
module afl_byte_collect
    import afl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    output mac_t       addr,
    output logic       addr_done
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] slot;
    logic             take;

    always_comb begin
        slot = start ? '0 : cnt;
        take = start || (byte_vld && (cnt < FULL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= FULL;
            addr      <= '0;
            addr_done <= 1'b0;
        end else begin
            addr_done <= take && (slot == LAST);
            if (take) begin
                addr[{slot, 3'b000} +: 8] <= byte_data;
                cnt                       <= slot + 1'b1;
            end
        end
    end

    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (cnt == FULL && !start) |=> !addr_done);

endmodule

// File: rtl/afl_ucast_cmp.sv
module afl_ucast_cmp
    import afl_pkg::*;
(
    input  logic enable,
    input  mac_t ref_addr,
    input  mac_t rx_addr,
    output logic hit
);
    logic same;

    always_comb begin
        same = (ref_addr == rx_addr);
        hit  = enable && same;
    end

endmodule

// File: rtl/afl_group_hash.sv
module afl_group_hash
    import afl_pkg::*;
(
    input  mac_t                rx_addr,
    input  logic [GRP_BITS-1:0] table_bits,
    input  logic                hash_all,
    output logic                hit
);
    localparam int HALF = GRP_BITS / 2;

    hidx_t           idx;
    logic [HALF-1:0] half_sel;
    logic            bit_sel;
    logic            eligible;

    always_comb begin
        idx      = fold_hash(rx_addr);
        half_sel = idx[HASH_W-1] ? table_bits[GRP_BITS-1:HALF] : table_bits[HALF-1:0];
        bit_sel  = half_sel[idx[HASH_W-2:0]];
        eligible = hash_all || rx_addr[0];
        hit      = eligible && bit_sel;
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import afl_pkg::*;
#(
    parameter int LEN_W         = 16,
    parameter int MIN_FRAME_LEN = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_sof,
    input  logic             rx_vld,
    input  logic [7:0]       rx_byte,
    input  logic [LEN_W-1:0] rx_len,
    input  logic [31:0]      uc0_lo,
    input  logic [15:0]      uc0_hi,
    input  logic [31:0]      uc1_lo,
    input  logic [15:0]      uc1_hi,
    input  logic [31:0]      grp_lo,
    input  logic [31:0]      grp_hi,
    input  logic [3:0]       rx_ctrl,
    output logic             dec_valid,
    output logic             dec_accept
);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME_LEN);

    logic   start;
    snap_t  snap;
    rxctl_t ctl_in;
    mac_t   rx_addr;
    logic   addr_done;
    hits_t  hits;
    logic   accept_n;

    assign start  = rx_sof && rx_vld;
    assign ctl_in = rxctl_t'(rx_ctrl);

    // Configuration image, frozen for the frame at its start
    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (start) begin
            snap.uc[0] <= mac_from_regs(uc0_lo, uc0_hi);
            snap.uc[1] <= mac_from_regs(uc1_lo, uc1_hi);
            snap.grp   <= {grp_hi, grp_lo};
            snap.ctl   <= ctl_in;
            snap.len_ok <= (rx_len >= MIN_LEN);
        end
    end

    afl_byte_collect u_collect (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .byte_vld  (rx_vld),
        .byte_data (rx_byte),
        .addr      (rx_addr),
        .addr_done (addr_done)
    );

    for (genvar e = 0; e < NUM_UC; e++) begin : g_uc
        afl_ucast_cmp u_cmp (
            .enable   (snap.ctl.uc_en[e]),
            .ref_addr (snap.uc[e]),
            .rx_addr  (rx_addr),
            .hit      (hits.uc[e])
        );
    end

    afl_group_hash u_grp (
        .rx_addr    (rx_addr),
        .table_bits (snap.grp),
        .hash_all   (snap.ctl.hash_all),
        .hit        (hits.grp)
    );

    assign hits.bcast = snap.ctl.bcast_en && (&rx_addr);
    assign accept_n   = ((|hits.uc) || hits.bcast || hits.grp) && snap.len_ok;

    // Decision register
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else if (start) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else if (addr_done) begin
            dec_valid  <= 1'b1;
            dec_accept <= accept_n;
        end
    end

    a_r8_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        start |=> !dec_valid);

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !start) |=> (dec_valid && $stable(dec_accept)));

    a_r8_rise_after_addr: assert property (@(posedge clk) disable iff (rst)
        $rose(dec_valid) |-> $past(addr_done));

    a_r7_short_drop: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !snap.len_ok) |-> !dec_accept);

    a_r5_group_eligible: assert property (@(posedge clk) disable iff (rst)
        hits.grp |-> (snap.ctl.hash_all || rx_addr[0]));

endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_sof, rx_vld;
    logic [7:0]  rx_byte;
    logic [15:0] rx_len;
    logic [31:0] uc0_lo, uc1_lo, grp_lo, grp_hi;
    logic [15:0] uc0_hi, uc1_hi;
    logic [3:0]  rx_ctrl;
    logic        dec_valid, dec_accept;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst(rst), .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .rx_len(rx_len), .uc0_lo(uc0_lo), .uc0_hi(uc0_hi), .uc1_lo(uc1_lo),
        .uc1_hi(uc1_hi), .grp_lo(grp_lo), .grp_hi(grp_hi), .rx_ctrl(rx_ctrl),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R8 actual=running expected=finished");
            report();
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_byte(input logic [31:0] lo, input logic [15:0] hi, input int k);
        if (k < 4) return lo[k*8 +: 8];
        return hi[(k-4)*8 +: 8];
    endfunction

    // Independent model of the acceptance rule
    function automatic logic model(input logic [47:0] a);
        logic [5:0] h;
        logic eq0, eq1, g;
        int   hi;
        h = '0;
        for (int i = 0; i < 48; i++) h[i % 6] = h[i % 6] ^ a[i];
        hi  = int'(h);
        eq0 = 1'b1;
        eq1 = 1'b1;
        for (int k = 0; k < 6; k++) begin
            if (a[k*8 +: 8] != reg_byte(uc0_lo, uc0_hi, k)) eq0 = 1'b0;
            if (a[k*8 +: 8] != reg_byte(uc1_lo, uc1_hi, k)) eq1 = 1'b0;
        end
        g = (hi < 32) ? grp_lo[hi] : grp_hi[hi - 32];
        return ((rx_ctrl[0] && eq0) || (rx_ctrl[1] && eq1) ||
                (rx_ctrl[3] && (a == 48'hFFFF_FFFF_FFFF)) ||
                ((rx_ctrl[2] || a[0]) && g)) && (rx_len >= 16'd12);
    endfunction

    task automatic put(input logic sof, input logic vld, input logic [7:0] b);
        @(negedge clk);
        rx_sof  = sof;
        rx_vld  = vld;
        rx_byte = b;
    endtask

    // Send address, check R8 timing, decision, and hold across payload (R10)
    task automatic run_frame(input logic [47:0] a, input string req);
        logic exp;
        exp = model(a);
        for (int i = 0; i < 6; i++) put(i == 0, 1'b1, a[i*8 +: 8]);
        put(1'b0, 1'b1, ~a[7:0]);
        chk("R8 not yet valid", dec_valid, 1'b0);
        put(1'b0, 1'b1, ~a[15:8]);
        chk("R8 valid", dec_valid, 1'b1);
        chk(req, dec_accept, exp);
        put(1'b0, 1'b1, ~a[23:16]);
        put(1'b0, 1'b0, 8'h00);
        chk("R10 payload ignored valid", dec_valid, 1'b1);
        chk("R10 payload ignored accept", dec_accept, exp);
    endtask

    task automatic clear_cfg();
        uc0_lo = '0; uc0_hi = '0; uc1_lo = '0; uc1_hi = '0;
        grp_lo = '0; grp_hi = '0; rx_ctrl = '0; rx_len = 16'd64;
    endtask

    initial begin
        logic [47:0] sa, sb;
        rst = 1'b1; rx_sof = 1'b0; rx_vld = 1'b0; rx_byte = '0;
        clear_cfg();
        repeat (3) @(negedge clk);
        chk("R11 reset valid", dec_valid, 1'b0);
        chk("R11 reset accept", dec_accept, 1'b0);
        rst = 1'b0;

        // R1 station entries and byte order
        sa = 48'h6655_4433_2210;
        uc0_lo = 32'h4433_2210; uc0_hi = 16'h6655;
        uc1_lo = 32'hDDCC_BBAA; uc1_hi = 16'h0FEE;
        rx_ctrl = 4'b0001;
        run_frame(sa, "R1 entry0 match");
        chk("R1 entry0 model", model(sa), 1'b1);
        run_frame(48'h7755_4433_2210, "R1 byte5 differs");
        rx_ctrl = 4'b0010;
        run_frame(48'h0FEE_DDCC_BBAA, "R1 entry1 match");
        // R2 disabled entries
        rx_ctrl = 4'b0000;
        run_frame(sa, "R2 entry0 disabled");
        run_frame(48'h0FEE_DDCC_BBAA, "R2 entry1 disabled");
        // R3 broadcast
        rx_ctrl = 4'b1000;
        run_frame(48'hFFFF_FFFF_FFFF, "R3 broadcast on");
        rx_ctrl = 4'b0000;
        run_frame(48'hFFFF_FFFF_FFFF, "R3 broadcast off");

        // R4 sweep of every group index, both polarities
        for (int idx = 0; idx < 64; idx++) begin
            logic [5:0] c7, c0;
            c7 = {5'b0, ~idx[0]};
            c0 = 6'(idx) ^ c7;
            sa = {c7, 36'h0, c0};
            rx_ctrl = 4'b0000;
            {grp_hi, grp_lo} = 64'h1 << idx;
            run_frame(sa, "R4 single bit set");
            {grp_hi, grp_lo} = ~(64'h1 << idx);
            run_frame(sa, "R4 single bit clear");
        end

        // R5 unicast address and the hash-all bit
        grp_lo = '1; grp_hi = '1;
        sa = 48'h1234_5678_9A02;
        rx_ctrl = 4'b0000;
        run_frame(sa, "R5 unicast not hashed");
        rx_ctrl = 4'b0100;
        run_frame(sa, "R5 hash all");

        // R7 length boundary
        clear_cfg();
        uc0_lo = 32'h4433_2210; uc0_hi = 16'h6655; rx_ctrl = 4'b0001;
        sa = 48'h6655_4433_2210;
        rx_len = 16'd11;
        run_frame(sa, "R7 length 11 drops");
        chk("R7 model", model(sa), 1'b0);
        rx_len = 16'd12;
        run_frame(sa, "R7 length 12 accepted");

        // R9 configuration change mid-frame
        put(1'b1, 1'b1, sa[7:0]);
        put(1'b0, 1'b1, sa[15:8]);
        uc0_lo = ~uc0_lo; rx_ctrl = 4'b0000; rx_len = 16'd5;
        for (int i = 2; i < 6; i++) put(1'b0, 1'b1, sa[i*8 +: 8]);
        put(1'b0, 1'b0, 8'h00);
        put(1'b0, 1'b0, 8'h00);
        chk("R9 snapshot valid", dec_valid, 1'b1);
        chk("R9 snapshot accept", dec_accept, 1'b1);
        rx_ctrl = 4'b1111;
        put(1'b0, 1'b0, 8'h00);
        chk("R8 hold after cfg write", dec_accept, 1'b1);
        rx_ctrl = 4'b0001; rx_len = 16'd64;
        run_frame(sa, "R9 next frame uses new cfg");

        // R10 aborted address
        uc0_lo = 32'h4433_2210;
        sb = 48'h0102_0304_0506;
        for (int i = 0; i < 3; i++) put(i == 0, 1'b1, sb[i*8 +: 8]);
        run_frame(sa, "R10 restart then match");
        for (int i = 0; i < 3; i++) put(i == 0, 1'b1, sa[i*8 +: 8]);
        run_frame(sb, "R10 restart then mismatch");

        // R6 all control combinations against mixed addresses
        for (int ctl = 0; ctl < 16; ctl++) begin
            uc0_lo = $urandom(); uc0_hi = 16'($urandom());
            uc1_lo = $urandom(); uc1_hi = 16'($urandom());
            grp_lo = $urandom(); grp_hi = $urandom();
            rx_ctrl = 4'(ctl);
            for (int t = 0; t < 20; t++) begin
                case (t % 4)
                    0: sa = {uc0_hi, uc0_lo};
                    1: sa = {uc1_hi, uc1_lo};
                    2: sa = 48'hFFFF_FFFF_FFFF;
                    default: sa = {16'($urandom()), $urandom()};
                endcase
                run_frame(sa, "R6 combined acceptance");
            end
        end

        report();
    end

endmodule